// File: doc/BRIEF.md
# Parity-Checked Window Watchdog

This block supervises a host processor through byte writes to a watchdog control register. Each write is a trigger and carries the watchdog settings: a time-out/window mode flag and a period select. A write is acted on only when the whole byte has even parity. After reset, and after every failure, the block opens a long open window. Any correctly coded write inside that window is accepted. After an accepted trigger the block runs the selected period. In window mode a trigger that arrives too early or too late is a failure. In time-out mode only a missing trigger is a failure.

Failures are counted in a saturating counter, and a mode controller receives the results. It gets a restart request once the count reaches a limit of one or two failures. It gets a fail-safe request while the counter is saturated. A rearm pulse from the mode controller, given on a return to normal operation or when supervision is re-enabled, opens a fresh long open window. A rearm pulse takes priority over a write in the same cycle.

The write port is a valid/ready stream that never applies back-pressure once out of reset. A byte is taken in every cycle where `wr_valid` and `wr_ready` are both high.

Top module: `wdt_spi_window`

## Requirements
- R1: While `rst` is high, every output is 0 except `long_open`, which is 1. `wr_ready` is 1 from the first clock edge after `rst` falls.
- R2: In the long open window (`long_open`=1) a good write at any window count from 0 to LONG_CYC-1 is accepted. If no good write arrives, a failure is raised at count LONG_CYC-1.
- R3: Write byte: bit 6 = 1 selects time-out mode, bits 5:4 are the period select, bit 7 is the checksum, and bits 3:0 are free. A byte with odd parity over bits 7:0 pulses `chk_err` one cycle later. It neither retriggers the watchdog nor changes the settings.
- R4: In window mode a good write at a window count below 3/5 of the period is a failure.
- R5: In window mode a good write at a count from 3/5 of the period up to 6/5 of the period minus one is accepted. It restarts the count at 0 and clears `long_open`.
- R6: After an accepted trigger, if no good write arrives by count 6/5 of the period minus one, a failure is raised.
- R7: In time-out mode a good write at any count up to 6/5 of the period minus one is accepted.
- R8: The period is BASE_CYC shifted left by the period select. The settings of an accepted write apply from the window that this write starts.
- R9: A failure pulses `fail_pulse`, opens a long open window and adds one to `fail_cnt`, which saturates at 3. An accepted trigger clears `fail_cnt` to 0.
- R10: `restart_req` pulses together with `fail_pulse` when the new count is at least the limit. The limit is 2 if `fail_limit_two` is high and 1 otherwise.
- R11: `failsafe_req` is high exactly while `fail_cnt` is 3.
- R12: A `rearm` pulse opens a new long open window starting at count 0 and leaves `fail_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte accepted when high together with valid |
| wr_data | input | 8 | Watchdog control byte |
| fail_limit_two | input | 1 | Restart after the second failure instead of the first |
| rearm | input | 1 | Pulse: open a new long open window |
| fail_pulse | output | 1 | One-cycle failure indication |
| fail_cnt | output | 2 | Saturating failure count |
| restart_req | output | 1 | One-cycle restart request |
| failsafe_req | output | 1 | Counter saturated |
| chk_err | output | 1 | One-cycle checksum error indication |
| long_open | output | 1 | Long open window in progress |

## Verification
The bench builds the block with BASE_CYC=20 and LONG_CYC=50. This gives periods of 20 and 40 cycles, with early/late boundaries at counts 12/23 and 24/47. Every boundary of the long window and of both periods can then be hit at the exact cycle, within a few hundred clocks. Repeating the long window several times also drives the failure counter into saturation and out again in a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_SEL_W = 2;

  typedef enum logic {PH_LONG = 1'b0, PH_RUN = 1'b1} wdt_phase_e;

  typedef struct packed {
    logic                 timeout_mode;
    logic [WDT_SEL_W-1:0] per_sel;
  } wdt_cfg_t;

  function automatic logic parity_even(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/wdt_cmd_decode.sv
module wdt_cmd_decode
  import wdt_pkg::*;
(
  input  logic       wr_valid,
  input  logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       trig_good,
  output logic       trig_bad,
  output wdt_cfg_t   cfg_new
);
  logic take;
  assign take      = wr_valid & wr_ready;
  assign trig_good = take & parity_even(wr_data);
  assign trig_bad  = take & ~parity_even(wr_data);
  assign cfg_new.timeout_mode = wr_data[6];
  assign cfg_new.per_sel      = wr_data[4 +: WDT_SEL_W];
endmodule

// File: rtl/wdt_limits.sv
module wdt_limits
  import wdt_pkg::*;
#(
  parameter int BASE_CYC = 1000,
  parameter int TW       = 16
) (
  input  logic [WDT_SEL_W-1:0] per_sel,
  output logic [TW-1:0]        closed_lim,
  output logic [TW-1:0]        open_lim
);
  localparam int SEL_N = 1 << WDT_SEL_W;
  logic [TW-1:0] closed_tab [SEL_N];
  logic [TW-1:0] open_tab   [SEL_N];

  for (genvar i = 0; i < SEL_N; i++) begin : g_per
    localparam int PER = BASE_CYC << i;
    assign closed_tab[i] = TW'(PER * 3 / 5);
    assign open_tab[i]   = TW'(PER * 6 / 5);
  end

  assign closed_lim = closed_tab[per_sel];
  assign open_lim   = open_tab[per_sel];
endmodule

// File: rtl/wdt_fail_ctr.sv
module wdt_fail_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail,
  input  logic             clear,
  input  logic             limit_two,
  output logic [CNT_W-1:0] cnt,
  output logic             restart_req,
  output logic             failsafe_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, lim;
  logic             restart_q;

  assign cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign lim     = limit_two ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= fail && (cnt_nxt >= lim);
      if (fail)       cnt_q <= cnt_nxt;
      else if (clear) cnt_q <= '0;
    end
  end

  assign cnt          = cnt_q;
  assign restart_req  = restart_q;
  assign failsafe_req = (cnt_q == CNT_MAX);
endmodule

// File: rtl/wdt_spi_window.sv
module wdt_spi_window
  import wdt_pkg::*;
#(
  parameter int BASE_CYC = 1000,
  parameter int LONG_CYC = 25000,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  input  logic             fail_limit_two,
  input  logic             rearm,
  output logic             fail_pulse,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             restart_req,
  output logic             failsafe_req,
  output logic             chk_err,
  output logic             long_open
);
  localparam int SEL_N    = 1 << WDT_SEL_W;
  localparam int OPEN_MAX = (BASE_CYC << (SEL_N - 1)) * 6 / 5;
  localparam int SPAN     = (LONG_CYC > OPEN_MAX) ? LONG_CYC : OPEN_MAX;
  localparam int TW       = $clog2(SPAN + 1);

  wdt_phase_e    phase_q;
  wdt_cfg_t      cfg_q, cfg_new;
  logic [TW-1:0] cnt_q, closed_lim, open_lim, win_end;
  logic          ready_q, fail_q, chk_q;
  logic          trig_good, trig_bad, early, accept, fail_ev;

  wdt_cmd_decode u_dec (
    .wr_valid (wr_valid),
    .wr_ready (ready_q),
    .wr_data  (wr_data),
    .trig_good(trig_good),
    .trig_bad (trig_bad),
    .cfg_new  (cfg_new)
  );

  wdt_limits #(.BASE_CYC(BASE_CYC), .TW(TW)) u_lim (
    .per_sel   (cfg_q.per_sel),
    .closed_lim(closed_lim),
    .open_lim  (open_lim)
  );

  // window end and trigger classification
  assign win_end = (phase_q == PH_LONG) ? TW'(LONG_CYC - 1) : open_lim - TW'(1);
  assign early   = (phase_q == PH_RUN) && !cfg_q.timeout_mode && (cnt_q < closed_lim);
  assign accept  = !rearm && trig_good && !early;
  assign fail_ev = !rearm && ((trig_good && early) || (!trig_good && cnt_q == win_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_LONG;
      cnt_q   <= '0;
      cfg_q   <= '0;
      ready_q <= 1'b0;
      fail_q  <= 1'b0;
      chk_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      fail_q  <= fail_ev;
      chk_q   <= trig_bad && !rearm;
      if (rearm || fail_ev) begin
        phase_q <= PH_LONG;
        cnt_q   <= '0;
      end else if (accept) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
        cfg_q   <= cfg_new;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  wdt_fail_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .fail        (fail_ev),
    .clear       (accept),
    .limit_two   (fail_limit_two),
    .cnt         (fail_cnt),
    .restart_req (restart_req),
    .failsafe_req(failsafe_req)
  );

  assign wr_ready   = ready_q;
  assign fail_pulse = fail_q;
  assign chk_err    = chk_q;
  assign long_open  = (phase_q == PH_LONG);
endmodule

// File: rtl/wdt_spi_window_chk.sv
module wdt_spi_window_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [7:0]       wr_data,
  input logic             rearm,
  input logic             fail_pulse,
  input logic [CNT_W-1:0] fail_cnt,
  input logic             restart_req,
  input logic             chk_err,
  input logic             long_open
);
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wr_ready);

  a_r3_bad_sum_flagged: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && (^wr_data) && !rearm) |=> chk_err);

  a_r9_fail_opens_long: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |-> long_open);

  a_r9_count_steps: assert property (@(posedge clk) disable iff (rst)
    (fail_cnt != $past(fail_cnt)) |-> (fail_cnt == '0 || fail_cnt == $past(fail_cnt) + 1'b1));

  a_r10_restart_with_fail: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> (fail_pulse && fail_cnt != '0));
endmodule

bind wdt_spi_window wdt_spi_window_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/wdt_spi_window_tb.sv
module wdt_spi_window_tb;
  localparam int BASE = 20;
  localparam int LONG = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fail_limit_two = 1'b0;
  logic       rearm = 1'b0;
  logic       wr_ready, fail_pulse, restart_req, failsafe_req, chk_err, long_open;
  logic [1:0] fail_cnt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_spi_window #(.BASE_CYC(BASE), .LONG_CYC(LONG), .CNT_W(2)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .fail_limit_two(fail_limit_two), .rearm(rearm), .fail_pulse(fail_pulse),
    .fail_cnt(fail_cnt), .restart_req(restart_req), .failsafe_req(failsafe_req),
    .chk_err(chk_err), .long_open(long_open)
  );

  function automatic logic [7:0] mk(input logic tmo, input logic [1:0] sel, input logic bad);
    logic [6:0] low;
    low = {tmo, sel, 4'b0000};
    return {(^low) ^ bad, low};
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // wait m cycles from the sync point, then write at window count m
  task automatic wr_at(input int m, input logic [7:0] b);
    repeat (m) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 fail_pulse in reset", fail_pulse, 0);
    chk("R1 fail_cnt in reset", fail_cnt, 0);
    chk("R1 restart in reset", restart_req, 0);
    chk("R1 failsafe in reset", failsafe_req, 0);
    chk("R1 chk_err in reset", chk_err, 0);
    chk("R1 long_open in reset", long_open, 1);
    rst = 1'b0;
    idle(1);
    chk("R1 wr_ready after reset", wr_ready, 1);
  endtask

  task automatic t_long_window;
    idle(LONG - 2);
    chk("R2 no fail before long end", fail_pulse, 0);
    idle(1);
    chk("R2 fail at long end", fail_pulse, 1);
    chk("R9 count after fail", fail_cnt, 1);
    chk("R10 restart at limit one", restart_req, 1);
    chk("R9 long after fail", long_open, 1);
    wr_at(LONG - 1, mk(0, 2'd0, 0));
    chk("R2 last long cycle accepted", fail_pulse, 0);
    chk("R9 count cleared", fail_cnt, 0);
    chk("R5 window running", long_open, 0);
  endtask

  task automatic t_window;
    wr_at(12, mk(0, 2'd0, 0));
    chk("R5 trigger at closed limit", fail_pulse, 0);
    wr_at(23, mk(0, 2'd0, 0));
    chk("R5 trigger at open end", fail_pulse, 0);
    wr_at(11, mk(0, 2'd0, 0));
    chk("R4 early trigger fails", fail_pulse, 1);
    chk("R4 count after early", fail_cnt, 1);
    wr_at(0, mk(0, 2'd0, 0));
    chk("R2 first long cycle accepted", fail_pulse, 0);
    idle(23);
    chk("R6 no fail before deadline", fail_pulse, 0);
    idle(1);
    chk("R6 missing trigger fails", fail_pulse, 1);
  endtask

  task automatic t_period;
    wr_at(0, mk(0, 2'd1, 0));
    wr_at(23, mk(0, 2'd1, 0));
    chk("R8 longer period early at 23", fail_pulse, 1);
    wr_at(0, mk(0, 2'd1, 0));
    wr_at(47, mk(0, 2'd1, 0));
    chk("R8 longer period ok at 47", fail_pulse, 0);
    chk("R8 count cleared", fail_cnt, 0);
  endtask

  task automatic t_timeout_mode;
    wr_at(30, mk(1, 2'd0, 0));
    chk("R7 switch to timeout mode", fail_pulse, 0);
    wr_at(0, mk(1, 2'd0, 0));
    chk("R7 immediate trigger ok", fail_pulse, 0);
    wr_at(5, mk(1, 2'd0, 0));
    chk("R7 early trigger ok", fail_pulse, 0);
    idle(24);
    chk("R7 missing trigger fails", fail_pulse, 1);
  endtask

  task automatic t_parity;
    wr_at(0, mk(1, 2'd3, 1));
    chk("R3 bad sum flagged in long", chk_err, 1);
    chk("R3 long window kept", long_open, 1);
    wr_at(0, mk(0, 2'd0, 0));
    wr_at(15, mk(1, 2'd1, 1));
    chk("R3 bad sum flagged", chk_err, 1);
    chk("R3 bad sum no fail", fail_pulse, 0);
    idle(7);
    chk("R3 no retrigger, no fail yet", fail_pulse, 0);
    idle(1);
    chk("R3 original deadline kept", fail_pulse, 1);
  endtask

  task automatic t_limits;
    fail_limit_two = 1'b1;
    wr_at(0, mk(0, 2'd0, 0));
    chk("R9 cleared again", fail_cnt, 0);
    wr_at(0, mk(0, 2'd0, 0));
    chk("R10 first fail no restart", restart_req, 0);
    chk("R10 count one", fail_cnt, 1);
    idle(LONG);
    chk("R10 second fail restart", restart_req, 1);
    chk("R11 not saturated", failsafe_req, 0);
    idle(LONG);
    chk("R9 count three", fail_cnt, 3);
    chk("R11 failsafe at three", failsafe_req, 1);
    idle(LONG);
    chk("R9 count saturates", fail_cnt, 3);
    wr_at(0, mk(0, 2'd0, 0));
    chk("R11 failsafe cleared", failsafe_req, 0);
    fail_limit_two = 1'b0;
  endtask

  task automatic t_rearm;
    wr_at(0, mk(0, 2'd0, 0));
    chk("R12 count one before rearm", fail_cnt, 1);
    idle(30);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    chk("R12 long after rearm", long_open, 1);
    chk("R12 count kept", fail_cnt, 1);
    idle(LONG - 1);
    chk("R12 window restarted", fail_pulse, 0);
    idle(1);
    chk("R12 fail at new long end", fail_pulse, 1);
    chk("R12 count continues", fail_cnt, 2);
  endtask

  initial begin
    idle(4);
    t_reset();
    t_long_window();
    t_window();
    t_period();
    t_timeout_mode();
    t_parity();
    t_limits();
    t_rearm();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule